// File: doc/BRIEF.md
# Programmable External Chip-Select Decoder

This block turns a 21-bit program-memory address into three active-low select lines for external memory devices. The address space is split into 8 KB pages, and the upper eight address bits are the page number. Two 8-bit configuration registers set the layout. The high-region register gives the first page of an upper region. The I/O-window register gives the single page of an 8 KB window. A fallback select covers every page that neither of the other two claims.

The window takes priority over the upper region wherever the two overlap. The top 512 bytes of the space are kept for internal execution and never drive an external select. No select is driven while no bus access is in progress.

Each select also has an enable flag. Pin-multiplexing logic uses this flag to choose between the chip-select function and general-purpose I/O.

Both registers are loaded through a one-cycle write strobe with a one-bit register selector. The address decode is combinational. A register write is seen by the decode from the next rising clock edge onward.

Top module: `cs_decoder`

## Requirements
- R1: After reset, both configuration registers hold FFh.
- R2: When the high-region register value H is nonzero, `csHighN` is low for an active bus address whose page (address bits 20:13) is at least H. The window select and the reserved range take precedence.
- R3: When H is 00h, `csHighN` stays high and `csHighEn` is low. Otherwise `csHighEn` is high.
- R4: When the window register value W is nonzero, `csIoN` is low for an active bus address whose page equals W. `csIoEn` is high exactly when W is nonzero.
- R5: On a page that lies in both the window and the upper region, `csIoN` is low and `csHighN` is high.
- R6: `csDefN` is low for every active, non-reserved address where neither `csHighN` nor `csIoN` is low, provided `csDefEn` is high.
- R7: `csDefEn` is high when H or W is nonzero. When both are 00h, `csDefEn` is low and `csDefN` stays high.
- R8: For addresses 1FFE00h to 1FFFFFh, all three selects are high.
- R9: While `busActive` is low, all three selects are high.
- R10: At most one of the three selects is low in any cycle.
- R11: A write with `cfgWrEn` high loads `cfgData` into the high-region register when `cfgSel` is 0, and into the window register when `cfgSel` is 1. The decode uses the new value from the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 1 | Register selector: 0 high-region, 1 window |
| cfgData | input | 8 | Value to write |
| busActive | input | 1 | High while an external access is in progress |
| addr | input | 21 | Program-memory byte address |
| csDefN | output | 1 | Fallback select, active low |
| csHighN | output | 1 | Upper-region select, active low |
| csIoN | output | 1 | 8 KB window select, active low |
| csDefEn | output | 1 | Fallback pin acts as chip select |
| csHighEn | output | 1 | Upper-region pin acts as chip select |
| csIoEn | output | 1 | Window pin acts as chip select |

## Verification
The selects and enable flags depend combinationally on `addr`, `busActive` and the two registers. They are therefore valid in the same cycle the address is applied. A configuration write is due one rising edge after the strobe.

The bench changes inputs one time unit after a rising edge. It compares every output with a behavioural model at the following falling edge. The model updates its register copies on the rising edge, so the write latency is checked against the old value before the edge and the new value after it.

// File: rtl/cs_decoder_pkg.sv
package cs_decoder_pkg;
  typedef struct packed {
    logic loadHigh;
    logic loadIo;
    logic busGate;
  } csStrobes_t;
endpackage

// File: rtl/cs_decoder_ctrl.sv
module cs_decoder_ctrl
  import cs_decoder_pkg::*;
(
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic       cfgSel,
  input  logic       busActive,
  output csStrobes_t strobes
);
  always_comb begin
    strobes.loadHigh = rstN & cfgWrEn & ~cfgSel;
    strobes.loadIo   = rstN & cfgWrEn &  cfgSel;
    strobes.busGate  = rstN & busActive;
  end
endmodule

// File: rtl/cs_decoder_dp.sv
module cs_decoder_dp
  import cs_decoder_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int PAGE_W    = 8,
  parameter int RES_BYTES = 512,
  parameter logic [PAGE_W-1:0] RESET_VAL = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  csStrobes_t        strobes,
  input  logic [PAGE_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] addr,
  output logic              csDefN,
  output logic              csHighN,
  output logic              csIoN,
  output logic              csDefEn,
  output logic              csHighEn,
  output logic              csIoEn
);
  localparam int PAGE_LSB = ADDR_W - PAGE_W;
  localparam logic [ADDR_W-1:0] RES_BASE = {ADDR_W{1'b1}} - ADDR_W'(RES_BYTES - 1);

  logic [PAGE_W-1:0] regHigh, regIo;
  logic [PAGE_W-1:0] page;
  logic inReserved, access, hitIo, hitHigh, hitDef;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regHigh <= RESET_VAL;
      regIo   <= RESET_VAL;
    end else begin
      if (strobes.loadHigh) regHigh <= cfgData;
      if (strobes.loadIo)   regIo   <= cfgData;
    end
  end

  assign page = addr[ADDR_W-1:PAGE_LSB];

  generate
    if (RES_BYTES > 0) begin : g_res
      assign inReserved = (addr >= RES_BASE);
    end else begin : g_nores
      assign inReserved = 1'b0;
    end
  endgenerate

  always_comb begin
    csHighEn = |regHigh;
    csIoEn   = |regIo;
    csDefEn  = csHighEn | csIoEn;
    access   = strobes.busGate & ~inReserved;
    hitIo    = csIoEn & (page == regIo);
    hitHigh  = csHighEn & (page >= regHigh) & ~hitIo;
    hitDef   = csDefEn & ~hitIo & ~hitHigh;
    csIoN    = ~(access & hitIo);
    csHighN  = ~(access & hitHigh);
    csDefN   = ~(access & hitDef);
  end

  // R10
  one_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~csDefN, ~csHighN, ~csIoN}) <= 1);
  // R8
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr >= RES_BASE) |-> (csDefN && csHighN && csIoN));
  // R5
  io_over_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csIoN) |-> csHighN);
  // R3
  high_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regHigh == '0) |-> (csHighN && !csHighEn));
  // R11
  load_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadIo |=> (regIo == $past(cfgData)));
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_decoder_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int PAGE_W    = 8,
  parameter int RES_BYTES = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [PAGE_W-1:0] cfgData,
  input  logic              busActive,
  input  logic [ADDR_W-1:0] addr,
  output logic              csDefN,
  output logic              csHighN,
  output logic              csIoN,
  output logic              csDefEn,
  output logic              csHighEn,
  output logic              csIoEn
);
  csStrobes_t strobes;

  cs_decoder_ctrl u_ctrl (
    .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .busActive(busActive), .strobes(strobes)
  );

  cs_decoder_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .RES_BYTES(RES_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgData(cfgData), .addr(addr),
    .csDefN(csDefN), .csHighN(csHighN), .csIoN(csIoN),
    .csDefEn(csDefEn), .csHighEn(csHighEn), .csIoEn(csIoEn)
  );

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busActive) |-> (csDefN && csHighN && csIoN));
endmodule

// File: tb/sim_cs_decoder.sv
module sim_cs_decoder;
  logic clk = 0, rstN = 0;
  logic cfgWrEn = 0, cfgSel = 0, busActive = 0;
  logic [7:0] cfgData = 0;
  logic [20:0] addr = 0;
  logic csDefN, csHighN, csIoN, csDefEn, csHighEn, csIoEn;
  int checks = 0, errors = 0;
  int mHigh = 255, mIo = 255;
  bit done = 0;

  always #2.5 clk = ~clk;

  cs_decoder u0 (.*);

  always @(posedge clk or negedge rstN)
    if (!rstN) begin mHigh = 255; mIo = 255; end
    else if (cfgWrEn) begin
      if (cfgSel) mIo = cfgData; else mHigh = cfgData;
    end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h addr=%0h", tag, act, exp, addr);
    end
  endtask

  always @(negedge clk) if (rstN && !done) begin
    int pg, eIo, eHi, eDf, act;
    pg  = int'(addr) >> 13;
    act = (busActive && int'(addr) < 'h1FFE00) ? 1 : 0;
    eIo = (mIo != 0 && pg == mIo) ? 1 : 0;
    eHi = (mHigh != 0 && pg >= mHigh && eIo == 0) ? 1 : 0;
    eDf = ((mHigh | mIo) != 0 && eIo == 0 && eHi == 0) ? 1 : 0;
    chk(csIoN   == !(act && eIo), "R4/R5/R8/R9/R11", csIoN,   !(act && eIo));
    chk(csHighN == !(act && eHi), "R2/R5/R8/R9/R11", csHighN, !(act && eHi));
    chk(csDefN  == !(act && eDf), "R6/R7/R8/R9",     csDefN,  !(act && eDf));
    chk(csHighEn == (mHigh != 0), "R3", csHighEn, mHigh != 0);
    chk(csIoEn   == (mIo != 0),   "R4", csIoEn,   mIo != 0);
    chk(csDefEn  == ((mHigh | mIo) != 0), "R7", csDefEn, (mHigh | mIo) != 0);
    chk(({2'b0,!csDefN} + {2'b0,!csHighN} + {2'b0,!csIoN}) <= 3'd1, "R10", 0, 0);
  end

  task automatic step(input logic [20:0] a, input bit bus);
    @(posedge clk); #1; addr = a; busActive = bus; cfgWrEn = 0;
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(posedge clk); #1; cfgWrEn = 1; cfgSel = sel; cfgData = d;
  endtask

  task automatic sweep();
    for (int p = 0; p < 256; p++) begin
      step(21'(p << 13), 1);
      step(21'((p << 13) | 'h1FFF), ($urandom % 8) != 0);
    end
    step(21'h1FFDFF, 1); step(21'h1FFE00, 1); step(21'h1FFFFF, 1);
    step(21'h03FFFF, 1); step(21'h040000, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1: reset values seen through the decode
    step(21'h1FE000, 1);
    @(negedge clk); chk(!csIoN && csHighN, "R1", csIoN, 0);
    step(21'h1FC000, 1);
    @(negedge clk); chk(!csDefN, "R1", csDefN, 0);
    sweep();
    wr(1'b0, 8'h20); wr(1'b1, 8'h80);
    // R11: old value still in force in the cycle of the write
    @(negedge clk); chk(csIoEn, "R11", csIoEn, 1);
    step(21'h100000, 1);
    @(negedge clk); chk(!csIoN && csHighN, "R5", csIoN, 0);
    step(21'h03FFFF, 1);
    @(negedge clk); chk(!csDefN, "R6", csDefN, 0);
    step(21'h040000, 1);
    @(negedge clk); chk(!csHighN, "R2", csHighN, 0);
    step(21'h1FFE10, 1);
    @(negedge clk); chk(csDefN && csHighN && csIoN, "R8", 0, 0);
    step(21'h040000, 0);
    @(negedge clk); chk(csHighN, "R9", csHighN, 1);
    sweep();
    wr(1'b1, 8'h00); wr(1'b0, 8'h80); sweep();
    wr(1'b0, 8'h00); wr(1'b1, 8'h80); sweep();
    step(21'h180000, 1);
    @(negedge clk); chk(csHighN && !csHighEn, "R3", csHighEn, 0);
    wr(1'b1, 8'h00); sweep();
    @(negedge clk); chk(!csDefEn && csDefN, "R7", csDefEn, 0);
    wr(1'b0, 8'h40); wr(1'b1, 8'h50); sweep();
    wr(1'b0, 8'h01); wr(1'b1, 8'hFF); sweep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule